// File: doc/BRIEF.md
# Edge-Gated Pulse Width and Period Timer

This block measures how long an external digital signal stays in a given state, or how long one of its cycles lasts, by counting prescaled clock ticks between two chosen edges of that signal. The signal is synchronised into the clock domain and split into rising and falling edge strobes. A measurement mode picks which edge starts the count and which edge ends it. At the ending edge the count freezes and an interrupt flag is raised. The frozen value can be read at leisure, because further edges are ignored until firmware acknowledges the flag.

Firmware sets the mode and the tick divider, waits for the interrupt, reads the count, and then pulses the clear input to arm the next measurement. The count saturates at all ones when the ending edge takes too long, and an overflow status marks such a result as out of range. Dropping the enable returns the block to its armed, cleared state.

Top module: `edge_width_timer`

## Requirements
- R1: After reset, count_o is 0, irq_o is 0 and ovf_o is 0, and the block waits for a start edge.
- R2: With mode_i equal to 00 or 11 (period), a rising edge of sig_i starts the count and the next rising edge ends it; falling edges between them have no effect.
- R3: With mode_i equal to 01 (low pulse), a falling edge of sig_i starts the count and the next rising edge ends it.
- R4: With mode_i equal to 10 (high pulse), a rising edge of sig_i starts the count and the next falling edge ends it.
- R5: The tick divider is N = 2^(div_sel_i+1) clocks (div_sel_i 0..3 gives 2, 4, 8, 16) and restarts at the start edge; if the ending change of sig_i comes D clocks after the starting change, the frozen count is floor((D-1)/N), and irq_o rises three clock edges after the ending change of sig_i.
- R6: irq_o is 0 while a measurement runs and becomes 1 when the ending edge is seen; from then on count_o stays constant.
- R7: While irq_o is 1, any edges on sig_i are ignored: count_o, irq_o and ovf_o do not change.
- R8: A one-cycle pulse on clr_i while irq_o is 1 clears irq_o, ovf_o and count_o to 0 and arms the next measurement; a pulse on clr_i while a measurement runs has no effect on its result.
- R9: If the count would exceed 255 before the ending edge, count_o holds at 255 and ovf_o becomes 1; the ending edge still raises irq_o.
- R10: While en_i is 0, the block is held armed with count_o, irq_o and ovf_o at 0, and an ongoing measurement is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, the undivided CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low holds the block cleared |
| mode_i | input | 2 | Edge pair: 00/11 period, 01 low pulse, 10 high pulse |
| div_sel_i | input | 2 | Tick divider select, N = 2^(div_sel_i+1) |
| sig_i | input | 1 | Asynchronous signal under measurement |
| clr_i | input | 1 | Acknowledge pulse that clears the flag and re-arms |
| count_o | output | 8 | Measured tick count, frozen while irq_o is 1 |
| irq_o | output | 1 | Measurement complete flag |
| ovf_o | output | 1 | Count saturated before the ending edge |

## Verification
The bench builds the timer with its default parameters: an 8-bit count, a four-step divider and a two-stage synchroniser. With those values every divider setting from 2 to 16 is exercised and saturation is reached by a single 600-clock pulse at the fastest tick, so the out-of-range case costs few cycles. Short intervals of two and three clocks probe the synchroniser latency and the restart of the divider at the start edge.

// File: rtl/ewt_pkg.sv
package ewt_pkg;
  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } ewt_state_e;

  typedef enum logic [1:0] {
    MD_PERIOD  = 2'd0,
    MD_LOW     = 2'd1,
    MD_HIGH    = 2'd2,
    MD_PERIOD2 = 2'd3
  } ewt_mode_e;
endpackage

// File: rtl/ewt_sync_edge.sv
module ewt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= sig_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  a_r5_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ewt_prescaler.sv
module ewt_prescaler #(
  parameter int PRE_W = 4,
  localparam int SEL_W = (PRE_W > 1) ? $clog2(PRE_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] mask;

  always_comb begin
    span = (PRE_W+1)'(2) << sel_i;
    mask = span[PRE_W-1:0] - PRE_W'(1);
  end

  assign tick_o = &(div_q | ~mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else                div_q <= div_q + PRE_W'(1);
  end

  a_r5_restart_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !tick_o);
endmodule

// File: rtl/ewt_core.sv
module ewt_core
  import ewt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic             restart_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ewt_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             start_ev, stop_ev;

  always_comb begin
    unique case (ewt_mode_e'(mode_i))
      MD_LOW:  begin start_ev = fall_i; stop_ev = rise_i; end
      MD_HIGH: begin start_ev = rise_i; stop_ev = fall_i; end
      default: begin start_ev = rise_i; stop_ev = rise_i; end
    endcase
  end

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    ovf_d     = ovf_q;
    restart_o = 1'b0;
    if (!en_i) begin
      state_d = ST_ARM;
      cnt_d   = '0;
      ovf_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ARM: if (start_ev) begin
          state_d   = ST_RUN;
          cnt_d     = '0;
          restart_o = 1'b1;
        end
        ST_RUN: begin
          if (stop_ev) begin
            state_d = ST_HOLD;
          end else if (tick_i) begin
            if (cnt_q == CNT_MAX) ovf_d = 1'b1;
            else                  cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: if (clr_i) begin
          state_d = ST_ARM;
          cnt_d   = '0;
          ovf_d   = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARM;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = (state_q == ST_HOLD);
  assign ovf_o = ovf_q;

  // R6 and R7: a raised flag freezes the result against any edge
  a_r7_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && en_i && !clr_i) |=>
      (state_q == ST_HOLD && $stable(cnt_q) && $stable(ovf_q)));

  a_r8_clr_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && en_i && clr_i) |=>
      (state_q == ST_ARM && cnt_q == '0 && !ovf_q));

  a_r9_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q == CNT_MAX && en_i) |=> (cnt_q == CNT_MAX));

  a_r9_ovf_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (cnt_q == CNT_MAX));

  a_r10_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_ARM && cnt_q == '0 && !ovf_q));

  a_r6_run_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !irq_o);
endmodule

// File: rtl/edge_width_timer.sv
module edge_width_timer #(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (PRE_W > 1) ? $clog2(PRE_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             sig_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             ovf_o
);
  logic rise, fall, tick, restart;

  ewt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  ewt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .sel_i     (div_sel_i),
    .tick_o    (tick)
  );

  ewt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .mode_i    (mode_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .tick_i    (tick),
    .clr_i     (clr_i),
    .restart_o (restart),
    .cnt_o     (count_o),
    .irq_o     (irq_o),
    .ovf_o     (ovf_o)
  );
endmodule

// File: tb/sim_edge_width_timer.sv
module sim_edge_width_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [1:0] div_sel_i = 2'd0;
  logic       sig_i = 1'b0;
  logic       clr_i = 1'b0;
  logic [7:0] count_o;
  logic       irq_o;
  logic       ovf_o;

  int tests = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  edge_width_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
    .div_sel_i(div_sel_i), .sig_i(sig_i), .clr_i(clr_i),
    .count_o(count_o), .irq_o(irq_o), .ovf_o(ovf_o)
  );

  // {mode[19:18], sel[17:16], clocks between start and stop change[15:0]}
  localparam int NVEC = 9;
  localparam logic [19:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 16'd21},
    {2'd1, 2'd1, 16'd30},
    {2'd2, 2'd2, 16'd9},
    {2'd3, 2'd0, 16'd5},
    {2'd2, 2'd0, 16'd2},
    {2'd1, 2'd3, 16'd100},
    {2'd0, 2'd1, 16'd3},
    {2'd2, 2'd3, 16'd250},
    {2'd0, 2'd0, 16'd600}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(input int d, input int sel);
    int raw = (d - 1) >> (sel + 1);
    return (raw > 255) ? 255 : raw;
  endfunction

  // Drives a start change, then the stop change d clocks later.
  task automatic start_meas(input logic [1:0] md, input logic [1:0] sel);
    logic pre = (md == 2'd1);
    mode_i = md;
    div_sel_i = sel;
    @(negedge clk_i) sig_i = pre;
    repeat (4) @(negedge clk_i);
    sig_i = ~pre;
  endtask

  task automatic finish_meas(input logic [1:0] md, input int d);
    logic pre = (md == 2'd1);
    if (md == 2'd0 || md == 2'd3) begin
      repeat (d / 2) @(negedge clk_i);
      sig_i = 1'b0;
      repeat (d - d / 2) @(negedge clk_i);
      sig_i = 1'b1;
    end else begin
      repeat (d) @(negedge clk_i);
      sig_i = pre;
    end
    repeat (4) @(negedge clk_i);
  endtask

  task automatic pulse_clr();
    @(negedge clk_i) clr_i = 1'b1;
    @(negedge clk_i) clr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 count", count_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 ovf", ovf_o, 0);
    rst_ni = 1'b1;
    en_i = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] md  = VEC[i][19:18];
      logic [1:0] sel = VEC[i][17:16];
      int         d   = int'(VEC[i][15:0]);
      int         raw = (d - 1) >> (sel + 1);
      start_meas(md, sel);
      finish_meas(md, d);
      // R2 period, R3 low, R4 high, R5 count formula, R9 saturation
      check($sformatf("R5 count vec%0d", i), count_o, exp_count(d, sel));
      check($sformatf("R6 irq vec%0d", i), irq_o, 1);
      check($sformatf("R9 ovf vec%0d", i), ovf_o, (raw > 255) ? 1 : 0);
      pulse_clr();
      check($sformatf("R8 clr irq vec%0d", i), irq_o, 0);
      check($sformatf("R8 clr count vec%0d", i), count_o, 0);
      check($sformatf("R8 clr ovf vec%0d", i), ovf_o, 0);
    end

    // R6: flag low mid-run, R5 irq latency of three edges after stop change
    start_meas(2'd2, 2'd0);
    repeat (10) @(negedge clk_i);
    check("R6 irq during run", irq_o, 0);
    repeat (10) @(negedge clk_i);
    sig_i = 1'b0;                       // D = 20
    repeat (2) @(negedge clk_i);
    check("R5 irq not before third edge", irq_o, 0);
    @(negedge clk_i);
    check("R5 irq at third edge", irq_o, 1);
    check("R4 high pulse count", count_o, exp_count(20, 0));

    // R7: edges while flag set are ignored
    repeat (3) begin
      @(negedge clk_i) sig_i = 1'b1;
      repeat (3) @(negedge clk_i);
      sig_i = 1'b0;
      repeat (3) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
    check("R7 count frozen", count_o, exp_count(20, 0));
    check("R7 irq held", irq_o, 1);
    check("R7 ovf unchanged", ovf_o, 0);
    pulse_clr();

    // R8: clear pulse during a run leaves the result intact
    start_meas(2'd2, 2'd0);
    repeat (10) @(negedge clk_i);
    clr_i = 1'b1;
    @(negedge clk_i) clr_i = 1'b0;
    repeat (29) @(negedge clk_i);
    sig_i = 1'b0;                       // D = 40
    repeat (4) @(negedge clk_i);
    check("R8 clr in run count", count_o, exp_count(40, 0));
    check("R8 clr in run irq", irq_o, 1);
    pulse_clr();

    // R2: falling edge in period mode does not end the count
    start_meas(2'd0, 2'd1);
    repeat (5) @(negedge clk_i);
    sig_i = 1'b0;
    repeat (6) @(negedge clk_i);
    check("R2 fall ignored in period", irq_o, 0);
    sig_i = 1'b1;                       // D = 11
    repeat (4) @(negedge clk_i);
    check("R2 period count", count_o, exp_count(11, 1));
    pulse_clr();

    // R10: disable abandons and clears
    start_meas(2'd3, 2'd0);
    repeat (30) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    check("R10 count cleared", count_o, 0);
    check("R10 irq low", irq_o, 0);
    sig_i = 1'b0;
    repeat (3) @(negedge clk_i);
    sig_i = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R10 held while disabled", irq_o, 0);
    check("R10 ovf low", ovf_o, 0);
    en_i = 1'b1;
    repeat (2) @(negedge clk_i);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule